// File: doc/BRIEF.md
# Target Disconnect Latency Timer

This block watches a PCI target interface of a host-to-PCI bridge and requests a disconnect when a data phase waits too long. It keeps two programmable durations. The first-phase duration applies from the start of a transaction until the first data phase completes. The later-phase duration applies after every completed data phase. Both are counted in PCI clocks.

The bridge runs in one of two clocking modes, and the mode changes what a programmed value means. In synchronous mode a field value is the number of waiting clocks allowed. In asynchronous mode three clocks are added to the field value, and only small values are legal. Writes that exceed the cap for the current bridge role and mode are saturated to that cap, and a sticky flag records that this happened. The expiry produces a single-clock request. The timer then stays idle until the next transaction start.

Top module: `disc_latency_timer`

## Requirements
- R1: After reset `disc_req` and `illegal_wr` are 0. The first-phase field holds 2 and the later-phase field holds 1. In synchronous mode the first disconnect therefore comes 3 edges after a start, and 2 edges after a completed phase.
- R2: In synchronous mode, with a first-phase field F, `disc_req` is seen high after the edge that lies F+1 edges after the edge that sampled `txn_start`, when `trdy` and `phase_done` stay low.
- R3: When `async_mode`=1, the limit in use is the field value plus 3, so the disconnect comes F+4 edges after the start edge.
- R4: A first-phase write is saturated to a cap chosen by `role_periph` (0 = primary, 1 = peripheral) and `async_mode`: 31 for primary/sync, 18 for primary/async, 16 for peripheral/sync, 2 for peripheral/async. Without a write strobe the field keeps its value.
- R5: A later-phase write is saturated to 2 when `async_mode`=1. In synchronous mode every 5-bit value is kept unchanged.
- R6: A write that is saturated sets `illegal_wr`. Only reset clears it, and later legal writes leave it set.
- R7: A `phase_done` edge during an active transaction restarts the count with the later-phase limit. A disconnect then comes S+1 edges later (S+4 in asynchronous mode), and no disconnect is seen in the cycle after that edge.
- R8: Clocks with `trdy` high are not counted, and no disconnect is seen in the cycle after them.
- R9: `disc_req` is high for exactly one cycle. Afterwards no further request is made until a new `txn_start`.
- R10: `txn_start` during a count restarts the timer with the first-phase limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock |
| rst_n | input | 1 | Active-low synchronous reset |
| async_mode | input | 1 | 1 = asynchronous clocking mode |
| role_periph | input | 1 | 1 = peripheral bridge role, 0 = primary |
| wr_init | input | 1 | Write strobe for the first-phase field |
| wr_subs | input | 1 | Write strobe for the later-phase field |
| wr_data | input | FIELD_W | Write value |
| txn_start | input | 1 | Transaction start strobe |
| phase_done | input | 1 | Data phase completed strobe |
| trdy | input | 1 | Target ready; pauses counting |
| disc_req | output | 1 | One-clock disconnect request |
| illegal_wr | output | 1 | Sticky saturated-write flag |

## Verification
The first-phase field is swept over all 32 values in all four role and mode combinations. Each measured latency shows whether the saturation cap and the asynchronous offset were applied. The later-phase field is swept over all values in both modes, and a phase completion is placed on the very next edge so that the first-phase limit cannot produce the result. Separate patterns cover a ready window, a restart in the middle of a count and a long idle period after expiry. Together they separate a pause from a restart, and a single pulse from a repeated one.

// File: rtl/dlt_pkg.sv
package dlt_pkg;
  localparam int ASYNC_OFFSET = 3;

  typedef enum logic [1:0] {
    CFG_PRI_SYNC  = 2'd0,
    CFG_PRI_ASYNC = 2'd1,
    CFG_PER_SYNC  = 2'd2,
    CFG_PER_ASYNC = 2'd3
  } bridge_cfg_e;

  function automatic bridge_cfg_e cfg_of(input logic periph, input logic async_m);
    return bridge_cfg_e'({periph, async_m});
  endfunction
endpackage

// File: rtl/dlt_regs.sv
module dlt_regs
  import dlt_pkg::*;
#(
  parameter int FIELD_W            = 5,
  parameter int INIT_MAX_PRI_SYNC  = 31,
  parameter int INIT_MAX_PRI_ASYNC = 18,
  parameter int INIT_MAX_PER_SYNC  = 16,
  parameter int INIT_MAX_PER_ASYNC = 2,
  parameter int SUBS_MAX_ASYNC     = 2,
  parameter int INIT_RST           = 2,
  parameter int SUBS_RST           = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               async_mode,
  input  logic               role_periph,
  input  logic               wr_init,
  input  logic               wr_subs,
  input  logic [FIELD_W-1:0] wr_data,
  output logic [FIELD_W-1:0] init_fld,
  output logic [FIELD_W-1:0] subs_fld,
  output logic               illegal_wr,
  output logic               clamp_hit
);
  localparam int FIELD_MAX = (1 << FIELD_W) - 1;

  function automatic int init_cap(input bridge_cfg_e c);
    case (c)
      CFG_PRI_SYNC:  return INIT_MAX_PRI_SYNC;
      CFG_PRI_ASYNC: return INIT_MAX_PRI_ASYNC;
      CFG_PER_SYNC:  return INIT_MAX_PER_SYNC;
      default:       return INIT_MAX_PER_ASYNC;
    endcase
  endfunction

  function automatic int subs_cap(input logic async_m);
    return async_m ? SUBS_MAX_ASYNC : FIELD_MAX;
  endfunction

  function automatic logic [FIELD_W-1:0] saturate(input logic [FIELD_W-1:0] v, input int cap);
    return (int'(v) > cap) ? FIELD_W'(cap) : v;
  endfunction

  int   cap_i, cap_s;
  logic over_i, over_s;

  always_comb begin
    cap_i     = init_cap(cfg_of(role_periph, async_mode));
    cap_s     = subs_cap(async_mode);
    over_i    = wr_init && (int'(wr_data) > cap_i);
    over_s    = wr_subs && (int'(wr_data) > cap_s);
    clamp_hit = over_i || over_s;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      init_fld   <= FIELD_W'(INIT_RST);
      subs_fld   <= FIELD_W'(SUBS_RST);
      illegal_wr <= 1'b0;
    end else begin
      if (wr_init) init_fld <= saturate(wr_data, cap_i);
      if (wr_subs) subs_fld <= saturate(wr_data, cap_s);
      if (clamp_hit) illegal_wr <= 1'b1;
    end
  end
endmodule

// File: rtl/dlt_counter.sv
module dlt_counter
  import dlt_pkg::*;
#(
  parameter int FIELD_W = 5,
  localparam int CNT_W  = FIELD_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               async_mode,
  input  logic [FIELD_W-1:0] init_fld,
  input  logic [FIELD_W-1:0] subs_fld,
  input  logic               txn_start,
  input  logic               phase_done,
  input  logic               trdy,
  output logic               disc_req,
  output logic               tmr_active,
  output logic               expire
);
  function automatic logic [CNT_W-1:0] eff_limit(input logic [FIELD_W-1:0] f, input logic async_m);
    return CNT_W'(f) + (async_m ? CNT_W'(ASYNC_OFFSET) : '0);
  endfunction

  logic [CNT_W-1:0] elapsed, lim;
  logic             first_ph, wait_clk;

  always_comb begin
    lim      = first_ph ? eff_limit(init_fld, async_mode) : eff_limit(subs_fld, async_mode);
    wait_clk = tmr_active && !txn_start && !phase_done && !trdy;
    expire   = wait_clk && (elapsed >= lim);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tmr_active <= 1'b0;
      first_ph   <= 1'b0;
      elapsed    <= '0;
      disc_req   <= 1'b0;
    end else begin
      disc_req <= expire;
      if (txn_start) begin
        tmr_active <= 1'b1;
        first_ph   <= 1'b1;
        elapsed    <= '0;
      end else if (tmr_active && phase_done) begin
        first_ph <= 1'b0;
        elapsed  <= '0;
      end else if (expire) begin
        tmr_active <= 1'b0;
      end else if (wait_clk) begin
        elapsed <= elapsed + 1'b1;
      end
    end
  end
endmodule

// File: rtl/disc_latency_timer.sv
module disc_latency_timer #(
  parameter int FIELD_W            = 5,
  parameter int INIT_MAX_PRI_SYNC  = 31,
  parameter int INIT_MAX_PRI_ASYNC = 18,
  parameter int INIT_MAX_PER_SYNC  = 16,
  parameter int INIT_MAX_PER_ASYNC = 2,
  parameter int SUBS_MAX_ASYNC     = 2,
  parameter int INIT_RST           = 2,
  parameter int SUBS_RST           = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               async_mode,
  input  logic               role_periph,
  input  logic               wr_init,
  input  logic               wr_subs,
  input  logic [FIELD_W-1:0] wr_data,
  input  logic               txn_start,
  input  logic               phase_done,
  input  logic               trdy,
  output logic               disc_req,
  output logic               illegal_wr
);
  logic [FIELD_W-1:0] init_fld, subs_fld;
  logic               clamp_hit, tmr_active, expire;

  dlt_regs #(
    .FIELD_W(FIELD_W),
    .INIT_MAX_PRI_SYNC(INIT_MAX_PRI_SYNC),
    .INIT_MAX_PRI_ASYNC(INIT_MAX_PRI_ASYNC),
    .INIT_MAX_PER_SYNC(INIT_MAX_PER_SYNC),
    .INIT_MAX_PER_ASYNC(INIT_MAX_PER_ASYNC),
    .SUBS_MAX_ASYNC(SUBS_MAX_ASYNC),
    .INIT_RST(INIT_RST),
    .SUBS_RST(SUBS_RST)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .async_mode(async_mode), .role_periph(role_periph),
    .wr_init(wr_init), .wr_subs(wr_subs), .wr_data(wr_data),
    .init_fld(init_fld), .subs_fld(subs_fld), .illegal_wr(illegal_wr), .clamp_hit(clamp_hit)
  );

  dlt_counter #(.FIELD_W(FIELD_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .async_mode(async_mode),
    .init_fld(init_fld), .subs_fld(subs_fld),
    .txn_start(txn_start), .phase_done(phase_done), .trdy(trdy),
    .disc_req(disc_req), .tmr_active(tmr_active), .expire(expire)
  );
endmodule

// File: rtl/dlt_checker.sv
module dlt_checker #(
  parameter int FIELD_W = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               async_mode,
  input logic               role_periph,
  input logic               wr_init,
  input logic               wr_subs,
  input logic               txn_start,
  input logic               phase_done,
  input logic               trdy,
  input logic               disc_req,
  input logic               illegal_wr,
  input logic               clamp_hit,
  input logic               expire,
  input logic               tmr_active,
  input logic [FIELD_W-1:0] init_fld,
  input logic [FIELD_W-1:0] subs_fld
);
  AST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    disc_req |=> !disc_req); // R9
  AST_EXPIRE_NEEDS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> !tmr_active || $past(txn_start)); // R9
  AST_READY_PAUSES: assert property (@(posedge clk) disable iff (!rst_n)
    trdy |=> !disc_req); // R8
  AST_PHASE_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
    phase_done |=> !disc_req); // R7
  AST_START_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    txn_start |=> !disc_req && tmr_active); // R10
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_wr |=> illegal_wr); // R6
  AST_FLAG_ON_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    clamp_hit |=> illegal_wr); // R6
  AST_SUBS_ASYNC_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_subs && async_mode |=> subs_fld <= FIELD_W'(2)); // R5
  AST_INIT_PER_ASYNC_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_init && async_mode && role_periph |=> init_fld <= FIELD_W'(2)); // R4
  AST_INIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_init |=> $stable(init_fld)); // R4
endmodule

bind disc_latency_timer dlt_checker #(.FIELD_W(FIELD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .async_mode(async_mode), .role_periph(role_periph),
  .wr_init(wr_init), .wr_subs(wr_subs), .txn_start(txn_start),
  .phase_done(phase_done), .trdy(trdy), .disc_req(disc_req),
  .illegal_wr(illegal_wr), .clamp_hit(clamp_hit), .expire(expire),
  .tmr_active(tmr_active), .init_fld(init_fld), .subs_fld(subs_fld)
);

// File: tb/tb_disc_latency_timer.sv
module tb_disc_latency_timer;
  localparam int FW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          async_mode = 1'b0, role_periph = 1'b0;
  logic          wr_init = 1'b0, wr_subs = 1'b0;
  logic [FW-1:0] wr_data = '0;
  logic          txn_start = 1'b0, phase_done = 1'b0, trdy = 1'b0;
  logic          disc_req, illegal_wr;

  int n_vec = 0, n_bad = 0, cyc = 0;
  bit done = 0;

  always #4 clk = ~clk;

  disc_latency_timer dut (
    .clk(clk), .rst_n(rst_n), .async_mode(async_mode), .role_periph(role_periph),
    .wr_init(wr_init), .wr_subs(wr_subs), .wr_data(wr_data),
    .txn_start(txn_start), .phase_done(phase_done), .trdy(trdy),
    .disc_req(disc_req), .illegal_wr(illegal_wr)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic wr(input bit subs, input int v);
    @(negedge clk);
    wr_data = FW'(v);
    if (subs) wr_subs = 1'b1; else wr_init = 1'b1;
    @(posedge clk);
    @(negedge clk); wr_init = 1'b0; wr_subs = 1'b0;
  endtask

  task automatic start();
    @(negedge clk); txn_start = 1'b1;
    @(posedge clk);
    @(negedge clk); txn_start = 1'b0;
  endtask

  // edges counted from the last strobe edge until disc_req seen; pulse width checked (R9)
  task automatic measure(output int n);
    n = 0;
    for (int k = 0; k < 80; k++) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (disc_req) break;
    end
    @(posedge clk); @(negedge clk);
    chk("R9 pulse width", int'(disc_req), 0);
  endtask

  function automatic int cap_init(input int role, input int md);
    int tbl[4] = '{31, 18, 16, 2};
    return tbl[role * 2 + md];
  endfunction

  initial begin
    int n, exp_f, lim;
    do_reset();
    // R1 reset state and default fields
    chk("R1 disc_req", int'(disc_req), 0);
    chk("R1 illegal_wr", int'(illegal_wr), 0);
    start(); measure(n);
    chk("R1 default first latency", n, 3);
    start();
    @(negedge clk); phase_done = 1'b1;
    @(posedge clk); @(negedge clk); phase_done = 1'b0;
    measure(n);
    chk("R1 default later latency", n, 2);

    // R2 R3 R4 R6: first-phase sweep
    for (int role = 0; role < 2; role++)
      for (int md = 0; md < 2; md++)
        for (int v = 0; v < 32; v++) begin
          do_reset();
          role_periph = role[0]; async_mode = md[0];
          wr(0, v);
          exp_f = (v > cap_init(role, md)) ? cap_init(role, md) : v;
          chk("R6 flag after first-phase write", int'(illegal_wr), int'(v > cap_init(role, md)));
          start(); measure(n);
          lim = exp_f + (md == 1 ? 3 : 0);
          chk(md == 1 ? "R3/R4 async first latency" : "R2/R4 sync first latency", n, lim + 1);
        end

    // R5 R7: later-phase sweep with immediate phase completion
    for (int md = 0; md < 2; md++)
      for (int v = 0; v < 32; v++) begin
        do_reset();
        role_periph = 1'b0; async_mode = md[0];
        wr(1, v);
        chk("R5 flag after later-phase write", int'(illegal_wr), int'(md == 1 && v > 2));
        start();
        @(negedge clk); phase_done = 1'b1;
        @(posedge clk); @(negedge clk); phase_done = 1'b0;
        chk("R7 no request after phase edge", int'(disc_req), 0);
        measure(n);
        exp_f = (md == 1 && v > 2) ? 2 : v;
        chk("R5/R7 later latency", n, exp_f + (md == 1 ? 3 : 0) + 2 - 1);
      end

    // R6: flag stays set after a legal write
    do_reset();
    async_mode = 1'b1; role_periph = 1'b1;
    wr(0, 9);
    wr(0, 1);
    chk("R6 sticky flag", int'(illegal_wr), 1);

    // R8: ready window pauses the count
    do_reset();
    async_mode = 1'b0; role_periph = 1'b0;
    wr(0, 4);
    @(negedge clk); trdy = 1'b1;
    start();
    for (int k = 0; k < 5; k++) begin
      @(posedge clk); @(negedge clk);
      chk("R8 no request while ready", int'(disc_req), 0);
    end
    trdy = 1'b0;
    measure(n);
    chk("R8 latency after ready window", n, 5);

    // R10: restart mid-count
    start();
    repeat (3) @(posedge clk);
    start(); measure(n);
    chk("R10 latency from restart", n, 5);

    // R9: no further request while idle
    begin
      int seen = 0;
      for (int k = 0; k < 40; k++) begin
        @(posedge clk); @(negedge clk);
        seen += int'(disc_req);
      end
      chk("R9 idle after expiry", seen, 0);
    end

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule